// File: doc/BRIEF.md
# Branch Misprediction Detect and Flush

This unit lives in the memory stage of an in-order pipeline. Each cycle it looks at the instruction resolving there and compares the address that instruction actually continues to with the address fetch assumed when it was fetched. Both sides are reduced to a "next PC". The actual next PC is the taken target for a taken branch and the fall-through address (PC + 4) otherwise. The predicted next PC is formed the same way from the predicted direction and target. A branch is mispredicted when the two directions differ, or when the two next PCs differ.

On a misprediction the unit raises a one-cycle pulse in the following cycle. In that cycle it redirects fetch to the correct address and drives a separate flush line to each earlier stage, so those stages drop their contents instead of passing them on. It also sends a training record to the predictor: the branch PC, the actual direction and the actual target. The same cycle it emits a release mask with one bit per architectural register. The mask covers every destination register held by the younger instructions being squashed, so that the scoreboard can mark those registers valid again and later instructions do not wait for writes that will never happen.

In the cycle right after a detection, the instruction then sitting in the memory stage is the one that followed the branch, and it is already dead. The unit disregards it.

Top module: `brmiss_flush`

## Requirements
- R1: After reset, redirect_valid, upd_valid, every flush line and every release_mask bit are 0.
- R2: A valid branch whose actual direction (1 = taken) differs from its predicted direction produces redirect_valid = 1 in the next cycle.
- R3: A valid branch taken both actually and by prediction, but with act_target different from pred_target, produces redirect_valid = 1 in the next cycle.
- R4: When the actual and predicted next PCs agree, nothing is raised. This covers both taken with equal targets, and not-taken on both sides whatever pred_target holds.
- R5: redirect_pc equals act_target when the branch was taken, and br_pc + 4 (modulo 2^PC_W) when it was not.
- R6: On a redirect, all NFL flush lines are 1 in that same cycle. The pulse lasts one cycle.
- R7: With a redirect, upd_valid = 1 and the update carries upd_pc = br_pc, upd_taken = act_taken and upd_target = act_target of the mispredicted branch.
- R8: With a redirect, bit k of release_mask is 1 exactly when some younger slot i had yng_valid[i] = 1, yng_wr[i] = 1 and destination k in the detection cycle. Slot i's destination is the field yng_dst[i*RA_W +: RA_W].
- R9: In the cycle after a detection, the instruction presented on the branch inputs is ignored and cannot cause a redirect.
- R10: An input with br_valid = 0 or br_is_branch = 0 never causes a redirect, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Memory-stage slot holds a live instruction |
| br_is_branch | input | 1 | That instruction is a control transfer |
| br_pc | input | PC_W | Its PC |
| act_taken | input | 1 | Resolved direction |
| act_target | input | PC_W | Resolved taken target |
| pred_taken | input | 1 | Direction assumed at fetch |
| pred_target | input | PC_W | Target assumed at fetch |
| yng_valid | input | NYNG | Younger in-flight slot is live |
| yng_wr | input | NYNG | Younger slot writes a register |
| yng_dst | input | NYNG*RA_W | Destination register per younger slot |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Correct next address |
| flush | output | NFL | One flush line per earlier stage |
| upd_valid | output | 1 | Predictor training strobe |
| upd_pc | output | PC_W | Branch PC to train |
| upd_taken | output | 1 | Outcome to train |
| upd_target | output | PC_W | Target to train |
| release_mask | output | NREG | Registers to mark valid |

## Verification
The bench builds the unit with PC_W = 16 and NREG = 8, and keeps NYNG = 2 and NFL = 3. The narrow PC makes the wrap of the fall-through address at 0xFFFC a short directed vector. The eight-register scoreboard lets every bit of the release mask be compared literally. Two younger slots are enough to test merged, single and suppressed destinations. Back-to-back mismatching branches exercise the one-cycle ignore window and the return to normal detection after it.

// File: rtl/brmiss_flush.sv
module brmiss_flush #(
  parameter int PC_W = 32,
  parameter int NREG = 32,
  parameter int NYNG = 2,
  parameter int NFL  = 3,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_valid,
  input  logic                 br_is_branch,
  input  logic [PC_W-1:0]      br_pc,
  input  logic                 act_taken,
  input  logic [PC_W-1:0]      act_target,
  input  logic                 pred_taken,
  input  logic [PC_W-1:0]      pred_target,
  input  logic [NYNG-1:0]      yng_valid,
  input  logic [NYNG-1:0]      yng_wr,
  input  logic [NYNG*RA_W-1:0] yng_dst,
  output logic                 redirect_valid,
  output logic [PC_W-1:0]      redirect_pc,
  output logic [NFL-1:0]       flush,
  output logic                 upd_valid,
  output logic [PC_W-1:0]      upd_pc,
  output logic                 upd_taken,
  output logic [PC_W-1:0]      upd_target,
  output logic [NREG-1:0]      release_mask
);

  logic            miss_q;
  logic [PC_W-1:0] seq_pc, act_nxt, pred_nxt;
  logic            miss;
  logic [NREG-1:0] rel_d;

  assign seq_pc   = br_pc + PC_W'(4);
  assign act_nxt  = act_taken  ? act_target  : seq_pc;
  assign pred_nxt = pred_taken ? pred_target : seq_pc;
  assign miss     = br_valid & br_is_branch & ~miss_q &
                    ((act_taken ^ pred_taken) | (act_nxt != pred_nxt));

  always_comb begin
    rel_d = '0;
    for (int i = 0; i < NYNG; i++)
      if (yng_valid[i] && yng_wr[i])
        rel_d = rel_d | (NREG'(1) << yng_dst[i*RA_W +: RA_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q       <= 1'b0;
      redirect_pc  <= '0;
      upd_pc       <= '0;
      upd_taken    <= 1'b0;
      upd_target   <= '0;
      release_mask <= '0;
    end else begin
      miss_q       <= miss;
      release_mask <= miss ? rel_d : '0;
      if (miss) begin
        redirect_pc <= act_nxt;
        upd_pc      <= br_pc;
        upd_taken   <= act_taken;
        upd_target  <= act_target;
      end
    end
  end

  assign redirect_valid = miss_q;
  assign upd_valid      = miss_q;
  assign flush          = {NFL{miss_q}};

endmodule

// File: rtl/brmiss_flush_chk.sv
module brmiss_flush_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic            br_is_branch,
  input logic [PC_W-1:0] br_pc,
  input logic            act_taken,
  input logic [PC_W-1:0] act_target,
  input logic            pred_taken,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc
);

  a_r10_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid || !br_is_branch) |=> !redirect_valid);

  a_r2_dir_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_is_branch && (act_taken != pred_taken) && !redirect_valid) |=> redirect_valid);

  a_r5_target: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_is_branch && (act_taken != pred_taken) && !redirect_valid) |=>
      (redirect_pc == ($past(act_taken) ? $past(act_target) : $past(br_pc) + PC_W'(4))));

  a_r4_both_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_taken && !pred_taken) |=> !redirect_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

endmodule

bind brmiss_flush brmiss_flush_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_is_branch(br_is_branch),
  .br_pc(br_pc), .act_taken(act_taken), .act_target(act_target),
  .pred_taken(pred_taken), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/brmiss_flush_bench.sv
`timescale 1ns/100ps
module brmiss_flush_bench;
  localparam int PC_W = 16;
  localparam int NREG = 8;
  localparam int NYNG = 2;
  localparam int NFL  = 3;
  localparam int RA_W = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 0, br_is_branch = 0, act_taken = 0, pred_taken = 0;
  logic [PC_W-1:0] br_pc = '0, act_target = '0, pred_target = '0;
  logic [NYNG-1:0] yng_valid = '0, yng_wr = '0;
  logic [NYNG*RA_W-1:0] yng_dst = '0;
  logic redirect_valid, upd_valid, upd_taken;
  logic [PC_W-1:0] redirect_pc, upd_pc, upd_target;
  logic [NFL-1:0] flush;
  logic [NREG-1:0] release_mask;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brmiss_flush #(.PC_W(PC_W), .NREG(NREG), .NYNG(NYNG), .NFL(NFL)) u_brmiss_flush (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_is_branch(br_is_branch),
    .br_pc(br_pc), .act_taken(act_taken), .act_target(act_target),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .yng_valid(yng_valid), .yng_wr(yng_wr), .yng_dst(yng_dst),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .release_mask(release_mask));

  // {is_branch, act_taken, act_target, pred_taken, pred_target, pc, exp_miss, exp_pc}
  localparam logic [67:0] VEC [8] = '{
    {1'b1, 1'b1, 16'h0100, 1'b0, 16'h0000, 16'h0040, 1'b1, 16'h0100},
    {1'b1, 1'b0, 16'h0000, 1'b1, 16'h0200, 16'h0040, 1'b1, 16'h0044},
    {1'b1, 1'b1, 16'h0300, 1'b1, 16'h0304, 16'h0080, 1'b1, 16'h0300},
    {1'b1, 1'b1, 16'h0300, 1'b1, 16'h0300, 16'h0080, 1'b0, 16'h0000},
    {1'b1, 1'b0, 16'h1234, 1'b0, 16'h5678, 16'h0090, 1'b0, 16'h0000},
    {1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'hFFFC, 1'b1, 16'h0000},
    {1'b0, 1'b1, 16'h0500, 1'b0, 16'h0000, 16'h00B0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'h0600, 1'b0, 16'h0000, 16'h00A0, 1'b1, 16'h0600}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic at, input logic [15:0] atg,
                       input logic pt, input logic [15:0] ptg, input logic [15:0] pc);
    @(negedge clk);
    br_valid = v; br_is_branch = b; act_taken = at; act_target = atg;
    pred_taken = pt; pred_target = ptg; br_pc = pc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(redirect_valid == 0 && upd_valid == 0 && flush == 0 && release_mask == 0,
        "R1 reset outputs", {redirect_valid, upd_valid, flush, release_mask}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      drive(1'b1, VEC[i][67], VEC[i][66], VEC[i][65:50], VEC[i][49], VEC[i][48:33], VEC[i][32:17]);
      chk(redirect_valid == VEC[i][16], "R2/R3/R4/R10 redirect", redirect_valid, VEC[i][16]);
      if (VEC[i][16]) begin
        chk(redirect_pc == VEC[i][15:0], "R5 redirect pc", redirect_pc, VEC[i][15:0]);
        chk(flush == 3'b111, "R6 flush lines", flush, 3'b111);
        chk(upd_valid && upd_pc == VEC[i][32:17] && upd_taken == VEC[i][66] && upd_target == VEC[i][65:50],
            "R7 predictor update", {upd_valid, upd_taken, upd_pc, upd_target},
            {1'b1, VEC[i][66], VEC[i][32:17], VEC[i][65:50]});
      end else begin
        chk(flush == 0 && upd_valid == 0, "R4 quiet", {flush, upd_valid}, 0);
      end
      idle();
      chk(redirect_valid == 0 && flush == 0, "R6 one-cycle pulse", {redirect_valid, flush}, 0);
    end

    drive(1'b0, 1'b1, 1'b1, 16'h0700, 1'b0, 16'h0, 16'h00C0);
    chk(redirect_valid == 0, "R10 invalid slot", redirect_valid, 0);

    drive(1'b1, 1'b1, 1'b1, 16'h0800, 1'b0, 16'h0, 16'h00D0);
    chk(redirect_valid == 1 && redirect_pc == 16'h0800, "R9 first detect", redirect_pc, 16'h0800);
    drive(1'b1, 1'b1, 1'b1, 16'h0900, 1'b0, 16'h0, 16'h00D4);
    chk(redirect_valid == 0, "R9 follower ignored", redirect_valid, 0);
    drive(1'b1, 1'b1, 1'b1, 16'h0A00, 1'b0, 16'h0, 16'h00D8);
    chk(redirect_valid == 1 && redirect_pc == 16'h0A00, "R9 detection resumes", redirect_pc, 16'h0A00);
    idle();

    @(negedge clk);
    yng_valid = 2'b11; yng_wr = 2'b11; yng_dst = {3'd5, 3'd3};
    drive(1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 16'h0B00, 16'h00E0);
    chk(release_mask == 8'b0010_1000, "R8 two destinations", release_mask, 8'b0010_1000);
    idle();
    chk(release_mask == 0, "R8 mask clears", release_mask, 0);
    @(negedge clk);
    yng_wr = 2'b01;
    drive(1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 16'h0B00, 16'h00E0);
    chk(release_mask == 8'b0000_1000, "R8 non-writer skipped", release_mask, 8'b0000_1000);
    idle();
    @(negedge clk);
    yng_valid = 2'b00; yng_wr = 2'b11;
    drive(1'b1, 1'b1, 1'b1, 16'h0C00, 1'b1, 16'h0C00, 16'h00E0);
    chk(redirect_valid == 0 && release_mask == 0, "R8 no release without miss", release_mask, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule